// File: doc/BRIEF.md
# Multi-mode 16-bit PWM timer

This block is a 16-bit timer/counter that drives four waveform outputs from one shared counter. A 3-bit mode field selects one of six behaviours: a plain interval timer, a frequency generator, single-slope PWM and three dual-slope PWM variants that differ only in when the overflow flag is raised. The counter advances on cycles where a tick input (standing in for a prescaled clock) is high and the run bit is set.

Period and compare values are double buffered. Software may write the buffers at any time, and the active values change only on the update event of the current mode or on a software update command. Five sticky interrupt flags (one overflow, one per compare channel) each have an enable. The interrupt line is high while any enabled flag is set. Software commands can force an update, restart the count and waveforms, or return the whole block to its reset state.

Register map (4-bit address, 16-bit data). CTRL at 0: bit 0 run, bit 1 count down, bits 6:4 mode, bits 11:8 channel enables. CMD at 1, write only: bit 0 update, bit 1 restart, bit 2 reset. IEN at 2 and IFLAG at 3: bit 0 overflow, bit n+1 compare channel n. CNT at 4, read/write. PERBUF at 5. Active period at 6, read only. CMPBUF n at 8+n. Active compare n at 12+n, read only. Reads of 1 and 7 return 0.

Top module: `pwm_timer16`

## Requirements
- R1: After reset, CTRL, IEN, IFLAG, CNT and all compare registers read 0. Period and period buffer read 0xFFFF. Waveforms and the interrupt line are low.
- R2: The count changes only on a cycle with tick high, run set and a non-reserved mode, except for CNT writes and restart/reset commands.
- R3: In normal mode (000) and frequency mode (001), counting up restarts at 0 on the step taken at TOP, and counting down reloads TOP on the step taken at 0. That step is both the update and the overflow event. TOP is the period in normal mode and active compare 0 in frequency mode.
- R4: Writes to the period and compare buffers leave the active values unchanged until an update event or an update command. The event then copies the buffer contents held before that edge.
- R5: In frequency mode, each enabled output toggles on every period event. In normal mode, outputs stay low.
- R6: Single-slope mode (011) always counts up and restarts at the period. An output goes low on the period step. Otherwise it goes high on the step where the count equals its compare. The update and overflow event is the step into 0.
- R7: In dual-slope modes (101, 110, 111), the count reverses on the step at a nonzero period and climbs again on the step at 0. An output goes low on a compare match while climbing and high on a match while descending. The update is at the bottom. Overflow is at the top (101), at both top and bottom (110), or at the bottom (111).
- R8: A count above TOP while counting up runs on to 0xFFFF and wraps to 0, raising that mode's period or bottom event.
- R9: Each flag sets on its event and stays set until software writes 1 to its bit; a set in the same cycle as a clear wins. The interrupt line equals the OR of flags ANDed with enables.
- R10: The update command copies the buffers at once. The restart command clears the count and waveforms, sets the climbing direction and leaves buffers and flags alone. The reset command returns every register to its R1 value.
- R11: A waveform output is low whenever its channel enable bit is clear.
- R12: In reserved modes (010, 100) the count holds and the outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse from the prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| wave_o | output | 4 | Waveform outputs, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a dual-slope run uses a nonzero period. They also assume that CNT writes and commands arrive only through the write port, so that a quiet port means that only the tick can move the count. The stimulus gives every dual-slope case a nonzero period buffer before the update that loads it. Wrap-around is reached by writing CNT close to 0xFFFF rather than by a long run. Flag clears are issued at free-running intervals, so some of them land on the same cycle as a set.

// File: rtl/pwm_timer16_pkg.sv
package pwm_timer16_pkg;

   typedef enum logic [2:0] {
      WG_NORMAL  = 3'b000,
      WG_FREQ    = 3'b001,
      WG_RSV2    = 3'b010,
      WG_SINGLE  = 3'b011,
      WG_RSV4    = 3'b100,
      WG_DS_TOP  = 3'b101,
      WG_DS_BOTH = 3'b110,
      WG_DS_BOT  = 3'b111
   } wg_mode_e;

   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
   localparam logic [ADDR_W-1:0] A_CMD    = 4'd1;
   localparam logic [ADDR_W-1:0] A_IEN    = 4'd2;
   localparam logic [ADDR_W-1:0] A_IFLAG  = 4'd3;
   localparam logic [ADDR_W-1:0] A_CNT    = 4'd4;
   localparam logic [ADDR_W-1:0] A_PERBUF = 4'd5;
   localparam logic [ADDR_W-1:0] A_PER    = 4'd6;

   // CTRL field positions
   localparam int C_RUN  = 0;
   localparam int C_DOWN = 1;
   localparam int C_MODE = 4;
   localparam int C_CHEN = 8;

   // CMD bit positions
   localparam int K_UPD     = 0;
   localparam int K_RESTART = 1;
   localparam int K_RESET   = 2;

   function automatic logic mode_is_dual(wg_mode_e m);
      return (m == WG_DS_TOP) || (m == WG_DS_BOTH) || (m == WG_DS_BOT);
   endfunction

   function automatic logic mode_is_rsv(wg_mode_e m);
      return (m == WG_RSV2) || (m == WG_RSV4);
   endfunction

endpackage

// File: rtl/pwm_timer16_regs.sv
module pwm_timer16_regs
   import pwm_timer16_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int N_CH    = 4,
   parameter logic [CNT_W-1:0] PER_RST = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_we,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [CNT_W-1:0]             reg_wdata,
   input  logic                         upd_evt,
   input  logic [N_CH:0]                flag_set,
   output logic                         soft_rst,
   output logic                         cmd_upd,
   output logic                         cmd_restart,
   output logic                         cnt_we,
   output logic                         run,
   output logic                         down,
   output wg_mode_e                     mode,
   output logic [N_CH-1:0]              chen,
   output logic [N_CH:0]                ien,
   output logic [N_CH:0]                flags,
   output logic [CNT_W-1:0]             per,
   output logic [CNT_W-1:0]             perbuf,
   output logic [N_CH-1:0][CNT_W-1:0]   cmp,
   output logic [N_CH-1:0][CNT_W-1:0]   cmpbuf
);

   localparam int NF = N_CH + 1;

   logic cmd_hit;
   logic [N_CH:0] flag_clr;
   logic do_load;

   assign cmd_hit     = reg_we && (reg_addr == A_CMD);
   assign soft_rst    = cmd_hit && reg_wdata[K_RESET];
   assign cmd_upd     = cmd_hit && reg_wdata[K_UPD];
   assign cmd_restart = cmd_hit && reg_wdata[K_RESTART];
   assign cnt_we      = reg_we && (reg_addr == A_CNT);
   assign flag_clr    = (reg_we && (reg_addr == A_IFLAG)) ? reg_wdata[NF-1:0] : '0;
   assign do_load     = upd_evt || cmd_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         down  <= 1'b0;
         mode  <= WG_NORMAL;
         chen  <= '0;
         ien   <= '0;
         flags <= '0;
         per   <= PER_RST;
         perbuf <= PER_RST;
      end else if (soft_rst) begin
         run   <= 1'b0;
         down  <= 1'b0;
         mode  <= WG_NORMAL;
         chen  <= '0;
         ien   <= '0;
         flags <= '0;
         per   <= PER_RST;
         perbuf <= PER_RST;
      end else begin
         if (reg_we && (reg_addr == A_CTRL)) begin
            run  <= reg_wdata[C_RUN];
            down <= reg_wdata[C_DOWN];
            mode <= wg_mode_e'(reg_wdata[C_MODE +: 3]);
            chen <= reg_wdata[C_CHEN +: N_CH];
         end
         if (reg_we && (reg_addr == A_IEN))
            ien <= reg_wdata[NF-1:0];
         flags <= (flags & ~flag_clr) | flag_set;
         if (do_load)
            per <= perbuf;
         if (reg_we && (reg_addr == A_PERBUF))
            perbuf <= reg_wdata;
      end
   end

   for (genvar n = 0; n < N_CH; n++) begin : g_cmp
      localparam logic [ADDR_W-1:0] BUF_ADDR = ADDR_W'(8 + n);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp[n]    <= '0;
            cmpbuf[n] <= '0;
         end else if (soft_rst) begin
            cmp[n]    <= '0;
            cmpbuf[n] <= '0;
         end else begin
            if (do_load)
               cmp[n] <= cmpbuf[n];
            if (reg_we && (reg_addr == BUF_ADDR))
               cmpbuf[n] <= reg_wdata;
         end
      end
   end

endmodule

// File: rtl/pwm_timer16_count.sv
module pwm_timer16_count
   import pwm_timer16_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int N_CH  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        restart,
   input  logic                        tick,
   input  logic                        run,
   input  logic                        down,
   input  wg_mode_e                    mode,
   input  logic [CNT_W-1:0]            per,
   input  logic [N_CH-1:0][CNT_W-1:0]  cmp,
   input  logic                        cnt_we,
   input  logic [CNT_W-1:0]            cnt_wdata,
   output logic [CNT_W-1:0]            cnt,
   output logic                        climb,
   output logic                        step,
   output logic                        period_evt,
   output logic                        upd_evt,
   output logic                        ovf_evt,
   output logic [N_CH-1:0]             match
);

   localparam logic [CNT_W-1:0] BOTTOM = '0;
   localparam logic [CNT_W-1:0] MAXV   = '1;
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

   logic [CNT_W-1:0] top_v;
   logic [CNT_W-1:0] nxt;
   logic             nclimb;
   logic             pe, te, be;
   logic             dual;
   logic             dn;

   assign dual  = mode_is_dual(mode);
   assign dn    = down && ((mode == WG_NORMAL) || (mode == WG_FREQ));
   assign top_v = (mode == WG_FREQ) ? cmp[0] : per;
   assign step  = tick && run && !mode_is_rsv(mode);

   always_comb begin
      nxt    = cnt;
      nclimb = climb;
      pe     = 1'b0;
      te     = 1'b0;
      be     = 1'b0;
      if (dual) begin
         if (climb) begin
            if ((cnt == top_v) && (top_v != BOTTOM)) begin
               nxt    = cnt - ONE;
               nclimb = 1'b0;
               te     = 1'b1;
            end else if (cnt == MAXV) begin
               nxt = BOTTOM;
               be  = 1'b1;
            end else begin
               nxt = cnt + ONE;
            end
         end else begin
            if (cnt == BOTTOM) begin
               nxt    = ONE;
               nclimb = 1'b1;
               be     = 1'b1;
            end else begin
               nxt = cnt - ONE;
            end
         end
      end else if (dn) begin
         if (cnt == BOTTOM) begin
            nxt = top_v;
            pe  = 1'b1;
         end else begin
            nxt = cnt - ONE;
         end
      end else begin
         if ((cnt == top_v) || (cnt == MAXV)) begin
            nxt = BOTTOM;
            pe  = 1'b1;
         end else begin
            nxt = cnt + ONE;
         end
      end
   end

   always_comb begin
      unique case (mode)
         WG_DS_TOP:  ovf_evt = step && te;
         WG_DS_BOTH: ovf_evt = step && (te || be);
         WG_DS_BOT:  ovf_evt = step && be;
         default:    ovf_evt = step && pe;
      endcase
   end

   assign upd_evt    = step && (dual ? be : pe);
   assign period_evt = step && pe;

   for (genvar n = 0; n < N_CH; n++) begin : g_match
      assign match[n] = step && (cnt == cmp[n]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= BOTTOM;
         climb <= 1'b1;
      end else if (clr || restart) begin
         cnt   <= BOTTOM;
         climb <= 1'b1;
      end else if (cnt_we) begin
         cnt <= cnt_wdata;
      end else if (step) begin
         cnt   <= nxt;
         climb <= nclimb;
      end
   end

endmodule

// File: rtl/pwm_timer16_wave.sv
module pwm_timer16_wave
   import pwm_timer16_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  wg_mode_e mode,
   input  logic     step,
   input  logic     period_evt,
   input  logic     match,
   input  logic     climb,
   output logic     wave
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave <= 1'b0;
      end else if (clr) begin
         wave <= 1'b0;
      end else begin
         unique case (mode)
            WG_FREQ: begin
               if (period_evt)
                  wave <= !wave;
            end
            WG_SINGLE: begin
               if (period_evt)
                  wave <= 1'b0;
               else if (match)
                  wave <= 1'b1;
            end
            WG_DS_TOP, WG_DS_BOTH, WG_DS_BOT: begin
               if (step && match)
                  wave <= !climb;
            end
            default: wave <= 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
   import pwm_timer16_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int N_CH  = 4,
   parameter logic [CNT_W-1:0] PER_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic [N_CH-1:0]   wave_o,
   output logic              irq_o
);

   localparam int NF = N_CH + 1;

   if (CNT_W < 12 || CNT_W > 32) begin : g_bad_width
      $error("pwm_timer16: CNT_W must be within 12..32");
   end
   if (N_CH < 1 || N_CH > 4) begin : g_bad_chan
      $error("pwm_timer16: N_CH must be within 1..4");
   end

   logic                       soft_rst, cmd_upd, cmd_restart, cnt_we;
   logic                       run, down;
   wg_mode_e                   mode;
   logic [N_CH-1:0]            chen;
   logic [N_CH:0]              ien, flags, flag_set;
   logic [CNT_W-1:0]           per, perbuf, cnt;
   logic [N_CH-1:0][CNT_W-1:0] cmp, cmpbuf;
   logic                       climb, step, period_evt, upd_evt, ovf_evt;
   logic [N_CH-1:0]            match;
   logic [N_CH-1:0]            wave;

   pwm_timer16_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .PER_RST(PER_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .upd_evt(upd_evt), .flag_set(flag_set),
      .soft_rst(soft_rst), .cmd_upd(cmd_upd), .cmd_restart(cmd_restart),
      .cnt_we(cnt_we), .run(run), .down(down), .mode(mode), .chen(chen),
      .ien(ien), .flags(flags), .per(per), .perbuf(perbuf),
      .cmp(cmp), .cmpbuf(cmpbuf)
   );

   pwm_timer16_count #(.CNT_W(CNT_W), .N_CH(N_CH)) u_count (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .restart(cmd_restart),
      .tick(tick), .run(run), .down(down), .mode(mode), .per(per),
      .cmp(cmp), .cnt_we(cnt_we), .cnt_wdata(reg_wdata), .cnt(cnt),
      .climb(climb), .step(step), .period_evt(period_evt),
      .upd_evt(upd_evt), .ovf_evt(ovf_evt), .match(match)
   );

   for (genvar n = 0; n < N_CH; n++) begin : g_ch
      pwm_timer16_wave u_wave (
         .clk(clk), .rst_n(rst_n), .clr(soft_rst || cmd_restart),
         .mode(mode), .step(step), .period_evt(period_evt),
         .match(match[n]), .climb(climb), .wave(wave[n])
      );
   end

   assign flag_set = {match, ovf_evt};
   assign wave_o   = wave & chen;
   assign irq_o    = |(flags & ien);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL: begin
            reg_rdata[C_RUN]          = run;
            reg_rdata[C_DOWN]         = down;
            reg_rdata[C_MODE +: 3]    = mode;
            reg_rdata[C_CHEN +: N_CH] = chen;
         end
         A_IEN:    reg_rdata[NF-1:0] = ien;
         A_IFLAG:  reg_rdata[NF-1:0] = flags;
         A_CNT:    reg_rdata = cnt;
         A_PERBUF: reg_rdata = perbuf;
         A_PER:    reg_rdata = per;
         default: begin
            for (int n = 0; n < N_CH; n++) begin
               if (reg_addr == 4'(8 + n))  reg_rdata = cmpbuf[n];
               if (reg_addr == 4'(12 + n)) reg_rdata = cmp[n];
            end
         end
      endcase
   end

endmodule

// File: rtl/pwm_timer16_chk.sv
module pwm_timer16_chk #(
   parameter int CNT_W = 16,
   parameter int N_CH  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              reg_we,
   input logic [3:0]        reg_addr,
   input logic [2:0]        mode,
   input logic              down,
   input logic              step,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  per,
   input logic [N_CH:0]     flags,
   input logic              upd_evt,
   input logic              cmd_upd,
   input logic              cmd_restart,
   input logic              soft_rst,
   input logic [N_CH-1:0]   wave_o
);

   // R2: no tick and a quiet port keep the count
   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reg_we) |=> $stable(cnt));

   // R4: active period changes only through an update
   a_r4_period_loads_on_update: assert property (@(posedge clk) disable iff (!rst_n)
      (per != $past(per)) |-> $past(upd_evt || cmd_upd || soft_rst));

   // R9: a flag falls only on a clear write or a reset command
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flags) & ~flags) != '0) |-> $past((reg_we && reg_addr == 4'd3) || soft_rst));

   // R10: restart leaves count and outputs at zero
   a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_restart |=> (cnt == '0) && (wave_o == '0));

   // R12: reserved modes freeze the count
   a_r12_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 3'b010 || mode == 3'b100) && !reg_we) |=> $stable(cnt));

   // R8: counting up from MAX in normal mode wraps to zero
   a_r8_wrap_from_max: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mode == 3'b000 && !down && cnt == '1 && !reg_we) |=> (cnt == '0));

   // R6: inside the period, single-slope never passes the period
   a_r6_single_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mode == 3'b011 && cnt < per && !reg_we) |=> (cnt <= $past(per)));

endmodule

bind pwm_timer16 pwm_timer16_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
   .mode(mode), .down(down), .step(step), .cnt(cnt), .per(per), .flags(flags),
   .upd_evt(upd_evt), .cmd_upd(cmd_upd), .cmd_restart(cmd_restart),
   .soft_rst(soft_rst), .wave_o(wave_o)
);

// File: tb/pwm_timer16_tb.sv
`timescale 1ns/1ps
module pwm_timer16_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic [3:0]  wave_o;
   logic        irq_o;

   int    n_checks = 0;
   int    n_err = 0;
   string cur_req = "R1 reset";
   bit    tick_rand = 1'b0;
   bit    done = 1'b0;

   always #10 clk = ~clk;

   pwm_timer16 u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wave_o(wave_o), .irq_o(irq_o)
   );

   // ---------------- behavioural reference ----------------
   int m_cnt, m_per, m_perbuf, m_mode, m_ien, m_flag, m_chen;
   int m_cmp[4], m_cmpbuf[4];
   bit m_climb, m_run, m_down;
   bit m_wave[4];

   task automatic m_reset();
      m_cnt = 0; m_climb = 1; m_per = 'hFFFF; m_perbuf = 'hFFFF;
      m_mode = 0; m_ien = 0; m_flag = 0; m_chen = 0; m_run = 0; m_down = 0;
      for (int i = 0; i < 4; i++) begin
         m_cmp[i] = 0; m_cmpbuf[i] = 0; m_wave[i] = 0;
      end
   endtask

   task automatic m_step();
      bit w = reg_we;
      int a = int'(reg_addr);
      int d = int'(reg_wdata);
      bit st, dual, pe, te, be, ups, ov, restart, updc;
      int topv, nx, setv, clrv;
      bit ncl;
      int old_perbuf;
      int old_cmpbuf[4];
      bit mt[4];
      if (w && a == 1 && (d & 4) != 0) begin
         m_reset();
         return;
      end
      restart = w && a == 1 && (d & 2) != 0;
      updc    = w && a == 1 && (d & 1) != 0;
      st   = tick && m_run && m_mode != 2 && m_mode != 4;
      dual = m_mode >= 5;
      topv = (m_mode == 1) ? m_cmp[0] : m_per;
      pe = 0; te = 0; be = 0; nx = m_cnt; ncl = m_climb;
      if (dual) begin
         if (m_climb) begin
            if (m_cnt == topv && topv != 0) begin nx = m_cnt - 1; ncl = 0; te = 1; end
            else if (m_cnt == 'hFFFF) begin nx = 0; be = 1; end
            else nx = m_cnt + 1;
         end else begin
            if (m_cnt == 0) begin nx = 1; ncl = 1; be = 1; end
            else nx = m_cnt - 1;
         end
      end else if (m_down && m_mode <= 1) begin
         if (m_cnt == 0) begin nx = topv; pe = 1; end
         else nx = m_cnt - 1;
      end else begin
         if (m_cnt == topv || m_cnt == 'hFFFF) begin nx = 0; pe = 1; end
         else nx = m_cnt + 1;
      end
      ups = st && (dual ? be : pe);
      case (m_mode)
         5: ov = st && te;
         6: ov = st && (te || be);
         7: ov = st && be;
         default: ov = st && pe;
      endcase
      setv = ov ? 1 : 0;
      for (int i = 0; i < 4; i++) begin
         mt[i] = st && (m_cnt == m_cmp[i]);
         if (mt[i]) setv |= (2 << i);
         case (m_mode)
            1: if (st && pe) m_wave[i] = !m_wave[i];
            3: if (st && pe) m_wave[i] = 0; else if (mt[i]) m_wave[i] = 1;
            5, 6, 7: if (mt[i]) m_wave[i] = !m_climb;
            default: m_wave[i] = 0;
         endcase
         if (restart) m_wave[i] = 0;
      end
      clrv = (w && a == 3) ? (d & 31) : 0;
      m_flag = (m_flag & ~clrv) | setv;
      if (restart) begin m_cnt = 0; m_climb = 1; end
      else if (w && a == 4) m_cnt = d;
      else if (st) begin m_cnt = nx & 'hFFFF; m_climb = ncl; end
      old_perbuf = m_perbuf;
      for (int i = 0; i < 4; i++) old_cmpbuf[i] = m_cmpbuf[i];
      if (ups || updc) begin
         m_per = old_perbuf;
         for (int i = 0; i < 4; i++) m_cmp[i] = old_cmpbuf[i];
      end
      if (w) begin
         case (a)
            0: begin
               m_run = d[0]; m_down = d[1]; m_mode = (d >> 4) & 7; m_chen = (d >> 8) & 15;
            end
            2: m_ien = d & 31;
            5: m_perbuf = d;
            8, 9, 10, 11: m_cmpbuf[a-8] = d;
            default: ;
         endcase
      end
   endtask

   function automatic int exp_rd(int a);
      case (a)
         0: return (m_run ? 1 : 0) | (m_down ? 2 : 0) | (m_mode << 4) | (m_chen << 8);
         2: return m_ien;
         3: return m_flag;
         4: return m_cnt;
         5: return m_perbuf;
         6: return m_per;
         8, 9, 10, 11: return m_cmpbuf[a-8];
         12, 13, 14, 15: return m_cmp[a-12];
         default: return 0;
      endcase
   endfunction

   function automatic int exp_wave();
      int v = 0;
      for (int i = 0; i < 4; i++) if (m_wave[i] && m_chen[i]) v |= (1 << i);
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else m_step();
   end

   task automatic chk(string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   // per-cycle comparison, well clear of both clock edges
   always @(posedge clk) begin
      #15;
      if (rst_n && !done) begin
         chk("wave_o", int'(wave_o), exp_wave());
         chk("irq_o", int'(irq_o), ((m_flag & m_ien) != 0) ? 1 : 0);
         chk($sformatf("rdata@%0d", reg_addr), int'(reg_rdata), exp_rd(int'(reg_addr)));
      end
   end

   always @(negedge clk) tick <= tick_rand ? 1'($urandom % 2) : 1'b1;

   // ---------------- stimulus helpers ----------------
   task automatic wr(int a, int d);
      @(negedge clk);
      reg_we <= 1'b1; reg_addr <= 4'(a); reg_wdata <= 16'(d);
      @(negedge clk);
      reg_we <= 1'b0;
   endtask

   task automatic run_cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         reg_addr <= 4'(i % 16);
      end
   endtask

   task automatic rd_expect(int a, int exp, string what);
      @(negedge clk);
      reg_addr <= 4'(a);
      #5;
      chk(what, int'(reg_rdata), exp);
   endtask

   function automatic int ctrl(int mode, int down, int run, int chen);
      return run | (down << 1) | (mode << 4) | (chen << 8);
   endfunction

   task automatic load(int p, int c0, int c1, int c2, int c3);
      wr(5, p); wr(8, c0); wr(9, c1); wr(10, c2); wr(11, c3);
      wr(1, 1);
   endtask

   // ---------------- test sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n <= 1'b1;

      cur_req = "R1 reset";
      rd_expect(6, 'hFFFF, "R1 period after reset");
      rd_expect(5, 'hFFFF, "R1 period buffer after reset");
      rd_expect(0, 0, "R1 ctrl after reset");
      rd_expect(3, 0, "R1 flags after reset");
      rd_expect(4, 0, "R1 count after reset");
      run_cyc(16);

      cur_req = "R2 tick gating";
      load(20, 5, 10, 15, 20);
      wr(0, ctrl(0, 0, 0, 15));
      run_cyc(10);
      rd_expect(4, 0, "R2 count held while stopped");
      tick_rand = 1'b1;
      wr(0, ctrl(0, 0, 1, 15));
      run_cyc(60);

      cur_req = "R3 normal up/down";
      tick_rand = 1'b0;
      wr(2, 31);
      run_cyc(50);
      wr(0, ctrl(0, 1, 1, 15));
      run_cyc(60);
      wr(3, 31);

      cur_req = "R4 buffered period";
      wr(5, 7);
      run_cyc(5);
      rd_expect(6, 20, "R4 active period before update");
      run_cyc(40);
      wr(0, ctrl(0, 0, 1, 15));
      wr(5, 12);
      run_cyc(30);

      cur_req = "R8 wrap through MAX";
      wr(4, 'hFFF0);
      run_cyc(30);
      wr(0, ctrl(3, 0, 1, 15));
      wr(4, 'hFFF8);
      run_cyc(30);

      cur_req = "R5 frequency mode";
      load(50, 3, 1, 2, 0);
      wr(0, ctrl(1, 0, 1, 15));
      run_cyc(40);
      wr(0, ctrl(1, 1, 1, 15));
      run_cyc(40);
      wr(8, 6);
      run_cyc(40);

      cur_req = "R6 single slope";
      load(12, 3, 6, 0, 12);
      wr(0, ctrl(3, 1, 1, 15));
      run_cyc(60);
      wr(9, 9);
      run_cyc(40);

      cur_req = "R7 dual slope ovf at top";
      load(10, 2, 5, 8, 0);
      wr(1, 2);
      wr(0, ctrl(5, 0, 1, 15));
      run_cyc(70);
      cur_req = "R7 dual slope ovf both";
      wr(3, 31);
      wr(0, ctrl(6, 0, 1, 15));
      run_cyc(70);
      cur_req = "R7 dual slope ovf at bottom";
      wr(3, 31);
      wr(0, ctrl(7, 0, 1, 15));
      wr(5, 6);
      run_cyc(70);
      tick_rand = 1'b1;
      run_cyc(60);
      tick_rand = 1'b0;

      cur_req = "R9 flags and interrupt";
      wr(2, 5);
      for (int k = 0; k < 20; k++) begin
         wr(3, (k % 2) ? 31 : 3);
         run_cyc(k % 5);
      end
      wr(2, 0);
      run_cyc(10);
      wr(2, 31);

      cur_req = "R11 channel enable";
      wr(0, ctrl(7, 0, 1, 5));
      run_cyc(50);
      wr(0, ctrl(7, 0, 1, 10));
      run_cyc(50);

      cur_req = "R12 reserved modes";
      wr(0, ctrl(2, 0, 1, 15));
      run_cyc(20);
      wr(0, ctrl(4, 0, 1, 15));
      run_cyc(20);

      cur_req = "R10 commands";
      wr(0, ctrl(3, 0, 1, 15));
      wr(5, 30); wr(8, 4);
      wr(1, 1);
      run_cyc(20);
      wr(1, 2);
      run_cyc(20);
      wr(0, ctrl(3, 0, 0, 15));
      wr(1, 2);
      rd_expect(4, 0, "R10 count after restart");
      rd_expect(6, 30, "R10 buffers kept by restart");
      wr(1, 4);
      rd_expect(0, 0, "R10 ctrl after reset command");
      rd_expect(6, 'hFFFF, "R10 period after reset command");
      run_cyc(16);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_err++;
         $display("FAIL watchdog %s: actual=timeout expected=finish", cur_req);
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

endmodule